// File: doc/BRIEF.md
# Programmable Wait-State Generator

This block stretches processor bus cycles for slow memory or peripherals. It watches the three active-low bus strobes: read, write and interrupt acknowledge. While none of them is asserted, a chain of fill stages is held at zero. Once any strobe is asserted, the chain fills with ones, one more stage on each rising clock edge. A wait-count select picks which stage, or tap, gates the ready line. While the device's active-low chip select is asserted and the chosen tap is still empty, the ready output is held low. The ready synchronizer that follows therefore inserts wait states until the tap fills.

The ready output is registered. Its value after a rising edge reflects the chip select, the wait-count select and the fill state as of that edge. Tap 0 is tied to "ready", so it disables stretching. Tap N (1 to 7 with the default sizing) gives N low cycles once a strobe begins. Address decoding and the ready synchronizer are outside the block.

Top module: `wait_state_gen`

## Requirements
- R1: A rising edge with `rst` high clears every fill stage and drives `rdy1` to 1. When `rst` falls with a strobe still asserted, counting restarts from zero.
- R2: An edge at which `rd_n`, `wr_n` and `inta_n` are all 1 empties the chain. A later strobe then yields the full selected wait count, even if an earlier strobe was cut short.
- R3: A strobe is asserted when it is 0. Each rising edge with at least one strobe asserted fills exactly one more stage, so `rdy1` stays low while the count of consecutive asserted edges is at most `wait_sel`.
- R4: With `cs_n`=0 and `wait_sel`=N (1..7), counting consecutive edges with a strobe asserted as k=1,2,…: after edge k, `rdy1` is 0 for k≤N and 1 for k≥N+1.
- R5: With `wait_sel`=1 and `cs_n`=0, `rdy1` is 0 after the first asserted edge and 1 after the second, which is exactly one wait state.
- R6: An edge with `cs_n`=1 drives `rdy1` to 1, whatever the strobes and the select.
- R7: An edge with `wait_sel`=0 drives `rdy1` to 1, even for a selected device.
- R8: An edge with all strobes at 1, `cs_n`=0 and `wait_sel`≠0 drives `rdy1` to 0.
- R9: Once `rdy1` has risen, it stays 1 while the strobe stays asserted and `cs_n` and `wait_sel` are unchanged, however long the cycle lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| inta_n | input | 1 | Active-low interrupt-acknowledge strobe |
| cs_n | input | 1 | Active-low chip select of the slow device |
| wait_sel | input | $clog2(STAGES) | Wait-state count; 0 disables stretching |
| rdy1 | output | 1 | Registered ready request to the synchronizer; 0 inserts a wait |

## Verification
The bound checker checks the following on every cycle:
- a deselected device, or a zero select, always gives a high ready on the next cycle;
- an idle, selected bus gives a low ready;
- the first asserted edge of a strobe gives a low ready;
- with a select of one, ready is high from the second asserted edge;
- a risen ready never drops while the strobe continues.

Only the bench's scenarios can show the following:
- the exact cycle at which ready rises for every select value;
- that an aborted strobe or a reset really restarts the count;
- that a long strobe saturates the chain without disturbing the ready line.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  typedef struct packed {
    logic rd_n;
    logic wr_n;
    logic ack_n;
  } bus_strobes_t;

  // Any strobe at 0 means a bus transfer is in progress.
  function automatic logic strobe_live(bus_strobes_t s);
    return ~(s.rd_n & s.wr_n & s.ack_n);
  endfunction

endpackage

// File: rtl/wsg_strobe_detect.sv
module wsg_strobe_detect
  import wsg_pkg::*;
(
  input  bus_strobes_t strobes,
  output logic         live
);

  always_comb live = strobe_live(strobes);

endmodule

// File: rtl/wsg_fill_chain.sv
module wsg_fill_chain #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              live,
  output logic [STAGES-2:0] fill_next_hi
);

  logic [STAGES-1:0] fill_d;
  logic [STAGES-1:0] fill_q;

  // Serial input of 1 while live; the whole chain is cleared when idle.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign fill_d[i] = live;
    end else begin : g_body
      assign fill_d[i] = live & fill_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fill_q <= '0;
    else     fill_q <= fill_d;
  end

  assign fill_next_hi = fill_d[STAGES-1:1];

endmodule

// File: rtl/wsg_tap_select.sv
module wsg_tap_select #(
  parameter int STAGES = 8,
  localparam int SEL_W = $clog2(STAGES)
) (
  input  logic [STAGES-2:0] fill_hi,
  input  logic [SEL_W-1:0]  sel,
  output logic              tap_full
);

  logic [STAGES-1:0] taps;

  for (genvar k = 0; k < STAGES; k++) begin : g_tap
    if (k == 0) begin : g_bypass
      assign taps[k] = 1'b1;
    end else begin : g_stage_tap
      assign taps[k] = fill_hi[k-1];
    end
  end

  always_comb tap_full = taps[sel];

endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
  parameter int STAGES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_n,
  input  logic                       wr_n,
  input  logic                       inta_n,
  input  logic                       cs_n,
  input  logic [$clog2(STAGES)-1:0]  wait_sel,
  output logic                       rdy1
);
  import wsg_pkg::*;

  localparam int SEL_W = $clog2(STAGES);

  bus_strobes_t      strobes;
  logic              live;
  logic [STAGES-2:0] fill_next_hi;
  logic              tap_full;

  assign strobes = '{rd_n: rd_n, wr_n: wr_n, ack_n: inta_n};

  wsg_strobe_detect u_detect (
    .strobes (strobes),
    .live    (live)
  );

  wsg_fill_chain #(.STAGES(STAGES)) u_chain (
    .clk          (clk),
    .rst          (rst),
    .live         (live),
    .fill_next_hi (fill_next_hi)
  );

  wsg_tap_select #(.STAGES(STAGES)) u_tap (
    .fill_hi  (fill_next_hi),
    .sel      (wait_sel[SEL_W-1:0]),
    .tap_full (tap_full)
  );

  // Registered ready: low only for a selected device whose tap is empty.
  always_ff @(posedge clk) begin
    if (rst) rdy1 <= 1'b1;
    else     rdy1 <= cs_n | tap_full;
  end

endmodule

// File: rtl/wait_state_gen_chk.sv
module wait_state_gen_chk #(
  parameter int STAGES = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      rd_n,
  input logic                      wr_n,
  input logic                      inta_n,
  input logic                      cs_n,
  input logic [$clog2(STAGES)-1:0] wait_sel,
  input logic                      rdy1
);

  logic live;
  logic past_ok;

  assign live = ~(rd_n & wr_n & inta_n);

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1
  reset_ready_chk: assert property (@(posedge clk) rst |=> rdy1);

  // R6
  deselect_ready_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> rdy1);

  // R7
  zero_sel_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_sel == '0) |=> rdy1);

  // R8
  idle_selected_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!live && !cs_n && wait_sel != '0) |=> !rdy1);

  // R4
  first_edge_low_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && live && !$past(live) && !cs_n && wait_sel != '0) |=> !rdy1);

  // R5
  one_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && live && $past(live) && !cs_n && wait_sel == 1) |=> rdy1);

  // R9
  hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && live && rdy1 && !cs_n && !$past(cs_n) &&
     wait_sel == $past(wait_sel)) |=> rdy1);

endmodule

bind wait_state_gen wait_state_gen_chk #(.STAGES(STAGES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .inta_n   (inta_n),
  .cs_n     (cs_n),
  .wait_sel (wait_sel),
  .rdy1     (rdy1)
);

// File: tb/tb_wait_state_gen.sv
module tb_wait_state_gen;

  localparam int STAGES = 8;
  localparam int SEL_W  = $clog2(STAGES);

  logic             clk = 1'b0;
  logic             rst;
  logic             rd_n, wr_n, inta_n, cs_n;
  logic [SEL_W-1:0] wait_sel;
  logic             rdy1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wait_state_gen #(.STAGES(STAGES)) dut (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
    .cs_n(cs_n), .wait_sel(wait_sel), .rdy1(rdy1)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rdy1=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle_bus();
    rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1;
  endtask

  // strobe kind: 0 read, 1 write, 2 interrupt acknowledge
  task automatic drive_strobe(input int kind);
    idle_bus();
    case (kind)
      0: rd_n = 1'b0;
      1: wr_n = 1'b0;
      default: inta_n = 1'b0;
    endcase
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_bus(); cs_n = 1'b0; wait_sel = 3'd3;
    step(); step();
    chk(rdy1, 1'b1, "R1 reset state");
    rst = 1'b0;
  endtask

  task automatic t_idle_selected();
    idle_bus(); cs_n = 1'b0; wait_sel = 3'd3;
    step();
    chk(rdy1, 1'b0, "R8 idle selected");
  endtask

  task automatic t_sweep();
    for (int n = 1; n < STAGES; n++) begin
      idle_bus(); cs_n = 1'b0; wait_sel = SEL_W'(n);
      step();
      chk(rdy1, 1'b0, "R8 idle before transfer");
      drive_strobe(n % 3);
      for (int i = 1; i <= n + 2; i++) begin
        step();
        if (n == 1)       chk(rdy1, i >= 2, "R5 single wait");
        else if (i <= n)  chk(rdy1, 1'b0, "R3 chain filling");
        else              chk(rdy1, 1'b1, "R4 tap reached");
      end
    end
    idle_bus();
    step();
  endtask

  task automatic t_abort_restart();
    idle_bus(); cs_n = 1'b0; wait_sel = 3'd5;
    step();
    rd_n = 1'b0;
    step(); step(); step();
    chk(rdy1, 1'b0, "R2 partial fill");
    idle_bus();
    step();
    wr_n = 1'b0;
    for (int i = 1; i <= 7; i++) begin
      step();
      chk(rdy1, i >= 6, "R2 count restarts after idle");
    end
    idle_bus();
    step();
  endtask

  task automatic t_reset_midcycle();
    idle_bus(); cs_n = 1'b0; wait_sel = 3'd3;
    step();
    rd_n = 1'b0;
    step(); step();
    rst = 1'b1;
    step();
    chk(rdy1, 1'b1, "R1 reset during strobe");
    rst = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      step();
      chk(rdy1, i >= 4, "R1 count restarts after reset");
    end
    idle_bus();
    step();
  endtask

  task automatic t_unselected();
    idle_bus(); cs_n = 1'b1; wait_sel = 3'd7;
    step();
    chk(rdy1, 1'b1, "R6 deselected idle");
    inta_n = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      step();
      chk(rdy1, 1'b1, "R6 deselected transfer");
    end
    cs_n = 1'b0;
    step();
    chk(rdy1, 1'b0, "R6 select mid-cycle with tap empty");
    idle_bus(); cs_n = 1'b1;
    step();
  endtask

  task automatic t_sel_zero();
    idle_bus(); cs_n = 1'b0; wait_sel = 3'd0;
    step();
    chk(rdy1, 1'b1, "R7 idle with zero select");
    wr_n = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      step();
      chk(rdy1, 1'b1, "R7 no waits with zero select");
    end
    idle_bus();
    step();
  endtask

  task automatic t_saturate();
    idle_bus(); cs_n = 1'b0; wait_sel = 3'd7;
    step();
    inta_n = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      step();
      if (i >= 8) chk(rdy1, 1'b1, "R9 ready holds on long strobe");
      else        chk(rdy1, 1'b0, "R4 longest wait");
    end
    idle_bus();
    step();
    chk(rdy1, 1'b0, "R2 cleared after long strobe");
  endtask

  initial begin
    t_reset();
    t_idle_selected();
    t_sweep();
    t_abort_restart();
    t_reset_midcycle();
    t_unselected();
    t_sel_zero();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule